// File: doc/BRIEF.md
# Infrared Receive Code Buffer with Interrupt Control

This block sits between an infrared pulse sampler and a host processor. The sampler hands over run-length codes one byte at a time on a push port, and it pulses a separate input when it has decided that a packet has ended. The block keeps these bytes in a first-in first-out store whose depth is a parameter, normally 16 or 64 entries. The host reaches the block through a small word-wide register bus, which has an address, write data, a write strobe, a read strobe and combinational read data.

Each read of the data register hands back the oldest byte and removes it from the store. A status register shows a live count of stored entries, together with three sticky pending flags: overflow, packet end and data available. The host clears these flags by writing ones to them. The interrupt output is high while any pending flag has its enable bit set. The data-available flag is raised whenever the stored count is greater than a trigger level that software programs.

Top module: `ir_rx_buffer`

## Requirements
- R1: After reset the control, status and interrupt-enable registers read zero, the store is empty and `irq` is low.
- R2: When both control bit 0 (global enable) and control bit 1 (receive enable) are set, each `code_valid` cycle stores `code_data`. Each read of the data register (offset 0x20) returns the oldest stored byte in bits 7:0 and removes it.
- R3: A push is ignored and the stored count stays unchanged while either enable bit is clear.
- R4: A push into a full store (count equal to DEPTH) drops the byte, leaves the count at DEPTH and sets the overflow pending flag, status bit 0.
- R5: A read of the data register while the store is empty returns zero and leaves the count at zero.
- R6: Status register (offset 0x30) bits starting at bit 8 hold the current stored count, in a field $clog2(DEPTH)+1 bits wide.
- R7: The data-available pending flag, status bit 4, is set one cycle after the count becomes greater than the trigger level, which sits in interrupt-enable register (offset 0x2C) bits starting at bit 8. It is not set while the count is at or below that level.
- R8: A `frame_end` pulse sets the packet-end pending flag, status bit 1, while both enables are on. A pulse is ignored while receive is disabled.
- R9: Writing a one to a status bit in 7:0 clears that pending flag. Writing zeros, or writing bits above 7, changes nothing. A set condition in the same cycle wins over the clear.
- R10: `irq` is the OR of each pending flag ANDed with its enable bit in the interrupt-enable register. Bit 0 enables overflow, bit 1 enables packet end and bit 4 enables data available.
- R11: Clearing control bit 0 empties the store and sets the count to zero.
- R12: Control bits 0, 1 and 5:4 (mode) read back as written. The receive-configuration register at offset 0x10 reads back its written low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_valid | input | 1 | Push strobe from the sampler |
| code_data | input | 8 | Run-length code byte |
| frame_end | input | 1 | Packet-end pulse from the sampler |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of the data register removes one entry |
| reg_rdata | output | 32 | Combinational register read data |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that each strobe on the register bus lasts exactly one cycle per access, and that the sampler holds `code_valid` for one cycle per byte. They do not assume that push and pop are mutually exclusive. The flag assertions take a simultaneous set and clear to resolve as set. The bench drives every access as a single-cycle strobe between falling edges. Its random phase mixes pushes and data reads, but it never issues both in the same cycle, so the queue model stays exact.

// File: rtl/irbuf_pkg.sv
package irbuf_pkg;

    localparam logic [7:0] A_CTRL  = 8'h00;
    localparam logic [7:0] A_RXCFG = 8'h10;
    localparam logic [7:0] A_DATA  = 8'h20;
    localparam logic [7:0] A_IEN   = 8'h2C;
    localparam logic [7:0] A_STAT  = 8'h30;

    localparam int NSRC      = 3;
    localparam int LEVEL_LSB = 8;

    typedef enum logic [1:0] {
        SRC_OVERRUN = 2'd0,
        SRC_PKT_END = 2'd1,
        SRC_AVAIL   = 2'd2
    } src_e;

    typedef struct packed {
        logic [1:0] mode;
        logic       rx_on;
        logic       glb_on;
    } ctrl_t;

    // Register bit used by each interrupt source (shared by enable and status).
    function automatic int src_bit(input int idx);
        case (idx)
            0:       return 0;
            1:       return 1;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/ir_byte_fifo.sv
module ir_byte_fifo #(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [7:0]       din,
    input  logic             pop,
    output logic [7:0]       head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            end
            if (do_pop) begin
                rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr] <= din;
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));                                   // R4
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !flush) |=> full);                // R4
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push && !flush) |=> empty);              // R5
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0));                                  // R11

endmodule

// File: rtl/ir_irq_ctrl.sv
module ir_irq_ctrl #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set_vec,
    input  logic [NSRC-1:0] clr_vec,
    input  logic [NSRC-1:0] en_vec,
    output logic [NSRC-1:0] pend,
    output logic            irq
);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                pend[i] <= 1'b0;
            end else if (set_vec[i]) begin
                pend[i] <= 1'b1;
            end else if (clr_vec[i]) begin
                pend[i] <= 1'b0;
            end
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            set_vec[i] |=> pend[i]);                               // R9
        AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
            (clr_vec[i] && !set_vec[i]) |=> !pend[i]);             // R9
    end

    assign irq = |(pend & en_vec);

endmodule

// File: rtl/ir_rx_buffer.sv
module ir_rx_buffer
    import irbuf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        code_valid,
    input  logic [7:0]  code_data,
    input  logic        frame_end,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    input  logic        reg_wr,
    input  logic        reg_rd,
    output logic [31:0] reg_rdata,
    output logic        irq
);

    localparam int CNT_W = $clog2(DEPTH) + 1;

    ctrl_t            ctrl;
    logic [7:0]       rxcfg;
    logic [NSRC-1:0]  src_en;
    logic [CNT_W-1:0] level;
    logic [NSRC-1:0]  pend, set_vec, clr_vec;
    logic [7:0]       head;
    logic [CNT_W-1:0] count;
    logic             full, empty, receiving, push_req, pop_req;

    assign receiving = ctrl.glb_on && ctrl.rx_on;
    assign push_req  = code_valid && receiving;
    assign pop_req   = reg_rd && (reg_addr == A_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            rxcfg  <= '0;
            src_en <= '0;
            level  <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_CTRL: begin
                    ctrl.glb_on <= reg_wdata[0];
                    ctrl.rx_on  <= reg_wdata[1];
                    ctrl.mode   <= reg_wdata[5:4];
                end
                A_RXCFG: rxcfg <= reg_wdata[7:0];
                A_IEN: begin
                    for (int i = 0; i < NSRC; i++) begin
                        src_en[i] <= reg_wdata[src_bit(i)];
                    end
                    level <= reg_wdata[LEVEL_LSB +: CNT_W];
                end
                default: ;
            endcase
        end
    end

    ir_byte_fifo #(.DEPTH(DEPTH)) i_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (!ctrl.glb_on),
        .push  (push_req),
        .din   (code_data),
        .pop   (pop_req),
        .head  (head),
        .count (count),
        .full  (full),
        .empty (empty)
    );

    always_comb begin
        set_vec              = '0;
        set_vec[SRC_OVERRUN] = push_req && full && !(pop_req && !empty);
        set_vec[SRC_PKT_END] = frame_end && receiving;
        set_vec[SRC_AVAIL]   = count > level;
        for (int i = 0; i < NSRC; i++) begin
            clr_vec[i] = reg_wr && (reg_addr == A_STAT) && reg_wdata[src_bit(i)];
        end
    end

    ir_irq_ctrl #(.NSRC(NSRC)) i_irq (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .en_vec  (src_en),
        .pend    (pend),
        .irq     (irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[0]   = ctrl.glb_on;
                reg_rdata[1]   = ctrl.rx_on;
                reg_rdata[5:4] = ctrl.mode;
            end
            A_RXCFG: reg_rdata[7:0] = rxcfg;
            A_DATA:  reg_rdata[7:0] = empty ? 8'h00 : head;
            A_IEN: begin
                for (int i = 0; i < NSRC; i++) begin
                    reg_rdata[src_bit(i)] = src_en[i];
                end
                reg_rdata[LEVEL_LSB +: CNT_W] = level;
            end
            A_STAT: begin
                for (int i = 0; i < NSRC; i++) begin
                    reg_rdata[src_bit(i)] = pend[i];
                end
                reg_rdata[LEVEL_LSB +: CNT_W] = count;
            end
            default: ;
        endcase
    end

    AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (rst)
        (code_valid && receiving && full && !pop_req) |=> pend[SRC_OVERRUN]);  // R4
    AST_IGNORED_PUSH: assert property (@(posedge clk) disable iff (rst)
        (code_valid && ctrl.glb_on && !ctrl.rx_on && !pop_req) |=> $stable(count)); // R3
    AST_PKT_END_FLAG: assert property (@(posedge clk) disable iff (rst)
        (frame_end && receiving) |=> pend[SRC_PKT_END]);                       // R8

endmodule

// File: tb/test_ir_rx_buffer.sv
module test_ir_rx_buffer;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        code_valid = 1'b0;
    logic [7:0]  code_data = '0;
    logic        frame_end = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] model_q[$];
    bit         model_ovf;

    always #4 clk = ~clk;

    ir_rx_buffer #(.DEPTH(DEPTH)) i_ir_rx_buffer (
        .clk(clk), .rst(rst), .code_valid(code_valid), .code_data(code_data),
        .frame_end(frame_end), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [31:0] stat_word(int cnt, bit ovf, bit pkt, bit avl);
        return (32'(cnt) << 8) | (avl ? 32'h10 : 32'h0) | (pkt ? 32'h2 : 32'h0) | (ovf ? 32'h1 : 32'h0);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        code_valid = 1'b1; code_data = b;
        @(negedge clk);
        code_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h00, v); check("R1 ctrl", v, 32'h0);
        rd(8'h30, v); check("R1 status", v, 32'h0);
        rd(8'h2C, v); check("R1 ienable", v, 32'h0);
        check("R1 irq", 32'(irq), 32'h0);

        // keep data-available out of the way: level = DEPTH
        wr(8'h2C, 32'(DEPTH) << 8);

        // R12 control and config readback
        wr(8'h00, 32'h33);
        rd(8'h00, v); check("R12 ctrl", v, 32'h33);
        wr(8'h10, 32'hFFFF_FF04);
        rd(8'h10, v); check("R12 rxcfg", v, 32'h04);

        // R3 push ignored with receive disabled
        wr(8'h00, 32'h31);
        push(8'hAA);
        rd(8'h30, v); check("R3 count", v, stat_word(0, 0, 0, 0));
        wr(8'h00, 32'h33);

        // R2 / R6 ordering and live count
        push(8'h11); push(8'h82); push(8'h7F);
        rd(8'h30, v); check("R6 count3", v, stat_word(3, 0, 0, 0));
        rd(8'h20, v); check("R2 byte0", v, 32'h11);
        rd(8'h30, v); check("R6 count2", v, stat_word(2, 0, 0, 0));
        rd(8'h20, v); check("R2 byte1", v, 32'h82);
        rd(8'h20, v); check("R2 byte2", v, 32'h7F);

        // R5 empty read
        rd(8'h20, v); check("R5 empty data", v, 32'h0);
        rd(8'h30, v); check("R5 empty count", v, stat_word(0, 0, 0, 0));

        // R4 overflow
        for (int i = 0; i < DEPTH + 1; i++) push(8'(i + 8'h40));
        rd(8'h30, v); check("R4 full+ovf", v, stat_word(DEPTH, 1, 0, 0));
        // R9 writes of zeros or upper bits change nothing
        wr(8'h30, 32'hFFFF_FF00);
        rd(8'h30, v); check("R9 no clear", v, stat_word(DEPTH, 1, 0, 0));
        // R10 enable overflow source
        wr(8'h2C, (32'(DEPTH) << 8) | 32'h1);
        idle(1);
        check("R10 irq on", 32'(irq), 32'h1);
        wr(8'h30, 32'h01);
        rd(8'h30, v); check("R9 cleared", v, stat_word(DEPTH, 0, 0, 0));
        check("R10 irq off", 32'(irq), 32'h0);
        rd(8'h20, v); check("R4 oldest kept", v, 32'h40);

        // R11 flush on global disable
        wr(8'h00, 32'h32);
        wr(8'h00, 32'h33);
        rd(8'h30, v); check("R11 flushed", v, stat_word(0, 0, 0, 0));

        // R7 trigger level
        wr(8'h2C, (32'd3 << 8) | 32'h10);
        push(8'h01); push(8'h02); push(8'h03);
        idle(2);
        rd(8'h30, v); check("R7 at level", v, stat_word(3, 0, 0, 0));
        check("R7 irq low", 32'(irq), 32'h0);
        push(8'h04);
        idle(2);
        rd(8'h30, v); check("R7 above level", v, stat_word(4, 0, 0, 1));
        check("R7 irq high", 32'(irq), 32'h1);
        for (int i = 0; i < 4; i++) rd(8'h20, v);
        wr(8'h30, 32'hFF);
        rd(8'h30, v); check("R7 drained", v, stat_word(0, 0, 0, 0));
        check("R10 irq drained", 32'(irq), 32'h0);

        // R8 packet end
        wr(8'h2C, (32'(DEPTH) << 8) | 32'h2);
        @(negedge clk); frame_end = 1'b1; @(negedge clk); frame_end = 1'b0;
        rd(8'h30, v); check("R8 flag", v, stat_word(0, 0, 1, 0));
        check("R8 irq", 32'(irq), 32'h1);
        wr(8'h30, 32'h02);
        wr(8'h00, 32'h31);
        @(negedge clk); frame_end = 1'b1; @(negedge clk); frame_end = 1'b0;
        rd(8'h30, v); check("R8 ignored", v, stat_word(0, 0, 0, 0));
        wr(8'h00, 32'h33);

        // random mix of pushes and reads (R2 R4 R5 R6)
        wr(8'h2C, 32'(DEPTH) << 8);
        model_q.delete();
        model_ovf = 0;
        for (int n = 0; n < 400; n++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op < 5) begin
                logic [7:0] b;
                b = 8'($urandom);
                push(b);
                if (model_q.size() < DEPTH) model_q.push_back(b);
                else model_ovf = 1;
            end else if (op < 9) begin
                logic [31:0] e;
                e = (model_q.size() > 0) ? 32'(model_q.pop_front()) : 32'h0;
                rd(8'h20, v); check("R2 random data", v, e);
            end else begin
                rd(8'h30, v); check("R6 random status", v, stat_word(model_q.size(), model_ovf, 0, 0));
            end
        end
        rd(8'h30, v); check("R6 final status", v, stat_word(model_q.size(), model_ovf, 0, 0));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule